// File: doc/BRIEF.md
# DRAM Burst-Series Address Generator

This block issues a continuous stream of memory request descriptors for stress traffic against a DRAM controller. Every descriptor holds a byte address, a write flag and the fixed burst size. Requests are grouped into series of `SEQ_LEN` requests. The first request of a series gets a pseudo-random start address, and bank, rank and column fields are then inserted according to a selectable bit layout. Every later request of the series steps to the next column of the same page, so one series stays on one open DRAM row.

The start address comes from a free-running LFSR. The random value is placed in a power-of-two window above `base_i`, aligned down to a burst, and given a bank below `BANKS_USED`, a rank below `RANKS` and a start column that leaves room for the whole series inside one page. Descriptors leave through a registered valid/ready handshake, and the generator advances only when a descriptor is accepted. A running total counts the bytes of all accepted requests.

Top module: `dram_series_gen`

## Requirements
- R1: While `rst_ni` is low, `req_valid_o` is 0 and `total_bytes_o` is 0. The first clock edge after release presents a descriptor, and `req_valid_o` stays 1 from then on.
- R2: While `req_valid_o` is 1 and `req_ready_i` is 0, `req_addr_o`, `req_we_o` and `req_size_o` hold their values at the next edge.
- R3: Every address is a multiple of `BURST_BYTES`, and `req_size_o` equals `BURST_BYTES`. A series start lies in [`base_i`, `base_i` + 2^`SPAN_BITS`), with `base_i` aligned to 2^`SPAN_BITS`.
- R4: The field layout is selected by `map_i`. With `map_i`=1 the layout is column-low: the column sits right above the burst offset, then bank, then rank. With `map_i`=0 the layout is bank-low: bank, then rank, then column. With the defaults, column-low puts the column at bits 9:5, the bank at 12:10 and the rank at 13. Bank-low puts the bank at 7:5, the rank at 8 and the column at 13:9. The bank field is always below `BANKS_USED` and the rank field below `RANKS`.
- R5: The column of a series start is at most `PAGE_BYTES/BURST_BYTES - SEQ_LEN`.
- R6: In the column-low layout, each non-first request of a series has the previous address plus `BURST_BYTES`.
- R7: In the bank-low layout, each non-first request equals the previous address with its column field incremented by one and all other bits unchanged.
- R8: A series is exactly `SEQ_LEN` accepted requests. A new series start follows every `SEQ_LEN`-th acceptance.
- R9: `map_i` and `rw_mode_i` are sampled only when a series start is generated. The write flag and the layout are constant within a series.
- R10: `rw_mode_i` selects the write flag, with `req_we_o`=1 meaning write. 0 gives all writes. 1 gives all reads. 2 inverts the flag at each series start. 3 takes a pseudo-random flag at each series start.
- R11: `total_bytes_o` increases by `BURST_BYTES` on every cycle with `req_valid_o` and `req_ready_i` both 1, and is unchanged otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_i | input | ADDR_W | Base of the random start window |
| map_i | input | 1 | Field layout: 1 column-low, 0 bank-low |
| rw_mode_i | input | 2 | Write-flag policy |
| req_valid_o | output | 1 | Descriptor valid |
| req_ready_i | input | 1 | Descriptor accepted when high with valid |
| req_addr_o | output | ADDR_W | Request byte address |
| req_we_o | output | 1 | 1 write, 0 read |
| req_size_o | output | log2(BURST_BYTES)+1 | Burst size in bytes |
| total_bytes_o | output | BYTES_W | Bytes of all accepted requests |

## Verification
The acceptance of the last request of a series falls in the same cycle as the generation of the next series start. In that cycle the count reloads, the layout and write policy are sampled, and the byte total grows. The bench provokes this with ready held high across many series boundaries, and also stalls exactly on the last request of a series while it changes layout and mode. It then judges the next start against the new settings and the previous series against the old ones, and checks the byte total at every cycle.

// File: rtl/dram_sgen_pkg.sv
package dram_sgen_pkg;
  typedef enum logic {
    MAP_BANK_LOW = 1'b0,
    MAP_COL_LOW  = 1'b1
  } map_e;

  typedef enum logic [1:0] {
    RW_WRITE = 2'b00,
    RW_READ  = 2'b01,
    RW_ALT   = 2'b10,
    RW_RAND  = 2'b11
  } rw_mode_e;
endpackage

// File: rtl/sgen_lfsr.sv
module sgen_lfsr #(
  parameter int          W    = 64,
  parameter logic [63:0] TAPS = 64'hD800_0000_0000_0000,
  parameter logic [63:0] SEED = 64'h1F2E_3D4C_5B6A_7988
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_d;

  // Galois form, shifting right
  always_comb begin
    state_d = {1'b0, state_q[W-1:1]};
    if (state_q[0]) state_d = state_d ^ TAPS[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED[W-1:0];
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/sgen_draw.sv
module sgen_draw #(
  parameter int RND_W       = 64,
  parameter int ADDR_W      = 32,
  parameter int SPAN_BITS   = 20,
  parameter int BLK_BITS    = 5,
  parameter int COL_BITS    = 5,
  parameter int BANK_BITS   = 3,
  parameter int RANK_W      = 1,
  parameter int COL_CHOICES = 29,
  parameter int BANKS_USED  = 4,
  parameter int RANKS       = 2
) (
  input  logic [RND_W-1:0]     rnd_i,
  input  logic [ADDR_W-1:0]    base_i,
  output logic [ADDR_W-1:0]    raw_o,
  output logic [BANK_BITS-1:0] bank_o,
  output logic [RANK_W-1:0]    rank_o,
  output logic [COL_BITS-1:0]  col_o,
  output logic                 coin_o
);
  localparam int COL_LSB  = SPAN_BITS;
  localparam int BANK_LSB = COL_LSB + COL_BITS;
  localparam int RANK_LSB = BANK_LSB + BANK_BITS;
  localparam int COIN_LSB = RANK_LSB + RANK_W;

  logic [ADDR_W-1:0] sum;

  assign sum   = base_i + ADDR_W'(rnd_i[SPAN_BITS-1:0]);
  assign raw_o = {sum[ADDR_W-1:BLK_BITS], {BLK_BITS{1'b0}}};

  // constant-divisor reductions into each legal range
  assign col_o  = COL_BITS'(32'(rnd_i[COL_LSB +: COL_BITS]) % 32'(COL_CHOICES));
  assign bank_o = BANK_BITS'(32'(rnd_i[BANK_LSB +: BANK_BITS]) % 32'(BANKS_USED));
  assign rank_o = RANK_W'(32'(rnd_i[RANK_LSB +: RANK_W]) % 32'(RANKS));
  assign coin_o = ^rnd_i[RND_W-1:COIN_LSB];
endmodule

// File: rtl/sgen_field_map.sv
module sgen_field_map #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BITS  = 5,
  parameter int COL_BITS  = 5,
  parameter int BANK_BITS = 3,
  parameter int RANK_BITS = 1,
  parameter int RANK_W    = 1
) (
  input  logic                 start_i,
  input  logic                 col_low_i,
  input  logic [ADDR_W-1:0]    raw_i,
  input  logic [ADDR_W-1:0]    prev_i,
  input  logic [BANK_BITS-1:0] bank_i,
  input  logic [RANK_W-1:0]    rank_i,
  input  logic [COL_BITS-1:0]  col_i,
  output logic [ADDR_W-1:0]    addr_o
);
  localparam int CL_COL  = BLK_BITS;
  localparam int CL_BANK = CL_COL + COL_BITS;
  localparam int CL_RANK = CL_BANK + BANK_BITS;
  localparam int BL_BANK = BLK_BITS;
  localparam int BL_RANK = BL_BANK + BANK_BITS;
  localparam int BL_COL  = BL_RANK + RANK_BITS;

  function automatic logic [ADDR_W-1:0] put_field(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] v,
                                                  input int pos, input int w);
    logic [ADDR_W-1:0] m;
    m = ((ADDR_W'(1) << w) - ADDR_W'(1)) << pos;
    return (a & ~m) | ((v << pos) & m);
  endfunction

  logic [ADDR_W-1:0]   cl_base, bl_base, cl_ins, bl_ins, cl_step, bl_step;
  logic [COL_BITS-1:0] bl_col_nxt;

  assign cl_base = put_field(put_field(raw_i, ADDR_W'(col_i), CL_COL, COL_BITS),
                             ADDR_W'(bank_i), CL_BANK, BANK_BITS);
  assign bl_base = put_field(put_field(raw_i, ADDR_W'(bank_i), BL_BANK, BANK_BITS),
                             ADDR_W'(col_i), BL_COL, COL_BITS);

  if (RANK_BITS > 0) begin : g_rank
    assign cl_ins = put_field(cl_base, ADDR_W'(rank_i), CL_RANK, RANK_BITS);
    assign bl_ins = put_field(bl_base, ADDR_W'(rank_i), BL_RANK, RANK_BITS);
  end else begin : g_no_rank
    logic unused_rank;
    assign unused_rank = ^rank_i;
    assign cl_ins = cl_base;
    assign bl_ins = bl_base;
  end

  // column sits above bank and rank: step only that field
  assign bl_col_nxt = prev_i[BL_COL +: COL_BITS] + COL_BITS'(1);
  assign bl_step    = put_field(prev_i, ADDR_W'(bl_col_nxt), BL_COL, COL_BITS);
  assign cl_step    = prev_i + (ADDR_W'(1) << BLK_BITS);

  always_comb begin
    if (start_i) addr_o = col_low_i ? cl_ins : bl_ins;
    else         addr_o = col_low_i ? cl_step : bl_step;
  end
endmodule

// File: rtl/dram_series_gen.sv
module dram_series_gen
  import dram_sgen_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          SPAN_BITS   = 20,
  parameter int          BURST_BYTES = 32,
  parameter int          PAGE_BYTES  = 1024,
  parameter int          BANKS       = 8,
  parameter int          BANKS_USED  = 4,
  parameter int          RANKS       = 2,
  parameter int          SEQ_LEN     = 4,
  parameter int          BYTES_W     = 32,
  parameter int          LFSR_W      = 64,
  parameter logic [63:0] LFSR_TAPS   = 64'hD800_0000_0000_0000,
  parameter logic [63:0] LFSR_SEED   = 64'h1F2E_3D4C_5B6A_7988
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [ADDR_W-1:0]              base_i,
  input  logic                           map_i,
  input  logic [1:0]                     rw_mode_i,
  output logic                           req_valid_o,
  input  logic                           req_ready_i,
  output logic [ADDR_W-1:0]              req_addr_o,
  output logic                           req_we_o,
  output logic [$clog2(BURST_BYTES):0]   req_size_o,
  output logic [BYTES_W-1:0]             total_bytes_o
);
  localparam int BLK_BITS    = $clog2(BURST_BYTES);
  localparam int COLS        = PAGE_BYTES / BURST_BYTES;
  localparam int COL_BITS    = $clog2(COLS);
  localparam int BANK_BITS   = $clog2(BANKS);
  localparam int RANK_BITS   = $clog2(RANKS);
  localparam int RANK_W      = (RANK_BITS > 0) ? RANK_BITS : 1;
  localparam int COL_CHOICES = COLS - SEQ_LEN + 1;
  localparam int CNT_W       = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam int SIZE_W      = BLK_BITS + 1;

  logic                 valid_q, we_q, col_low_q;
  logic [ADDR_W-1:0]    addr_q, next_addr;
  logic [CNT_W-1:0]     cnt_q;
  logic [BYTES_W-1:0]   bytes_q;
  logic [LFSR_W-1:0]    rnd;
  logic [ADDR_W-1:0]    raw;
  logic [BANK_BITS-1:0] bank;
  logic [RANK_W-1:0]    rank;
  logic [COL_BITS-1:0]  col;
  logic                 coin, we_pick, map_sel;
  logic                 produce, handshake, start;
  rw_mode_e             mode;

  sgen_lfsr #(
    .W    (LFSR_W),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED)
  ) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (rnd)
  );

  sgen_draw #(
    .RND_W       (LFSR_W),
    .ADDR_W      (ADDR_W),
    .SPAN_BITS   (SPAN_BITS),
    .BLK_BITS    (BLK_BITS),
    .COL_BITS    (COL_BITS),
    .BANK_BITS   (BANK_BITS),
    .RANK_W      (RANK_W),
    .COL_CHOICES (COL_CHOICES),
    .BANKS_USED  (BANKS_USED),
    .RANKS       (RANKS)
  ) i_draw (
    .rnd_i  (rnd),
    .base_i (base_i),
    .raw_o  (raw),
    .bank_o (bank),
    .rank_o (rank),
    .col_o  (col),
    .coin_o (coin)
  );

  assign handshake = valid_q && req_ready_i;
  assign produce   = !valid_q || req_ready_i;
  assign start     = (cnt_q == '0);
  assign map_sel   = start ? map_i : col_low_q;
  assign mode      = rw_mode_e'(rw_mode_i);

  sgen_field_map #(
    .ADDR_W    (ADDR_W),
    .BLK_BITS  (BLK_BITS),
    .COL_BITS  (COL_BITS),
    .BANK_BITS (BANK_BITS),
    .RANK_BITS (RANK_BITS),
    .RANK_W    (RANK_W)
  ) i_field_map (
    .start_i   (start),
    .col_low_i (map_sel),
    .raw_i     (raw),
    .prev_i    (addr_q),
    .bank_i    (bank),
    .rank_i    (rank),
    .col_i     (col),
    .addr_o    (next_addr)
  );

  always_comb begin
    unique case (mode)
      RW_WRITE: we_pick = 1'b1;
      RW_READ:  we_pick = 1'b0;
      RW_ALT:   we_pick = ~we_q;
      default:  we_pick = coin;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      addr_q    <= '0;
      we_q      <= 1'b0;
      col_low_q <= MAP_COL_LOW;
      cnt_q     <= '0;
      bytes_q   <= '0;
    end else begin
      if (produce) begin
        valid_q <= 1'b1;
        addr_q  <= next_addr;
        if (start) begin
          cnt_q     <= CNT_W'(SEQ_LEN - 1);
          col_low_q <= map_i;
          we_q      <= we_pick;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
      if (handshake) bytes_q <= bytes_q + BYTES_W'(BURST_BYTES);
    end
  end

  assign req_valid_o   = valid_q;
  assign req_addr_o    = addr_q;
  assign req_we_o      = we_q;
  assign req_size_o    = SIZE_W'(BURST_BYTES);
  assign total_bytes_o = bytes_q;
endmodule

// File: rtl/sgen_checker.sv
module sgen_checker #(
  parameter int ADDR_W      = 32,
  parameter int BURST_BYTES = 32,
  parameter int BLK_BITS    = 5,
  parameter int COL_BITS    = 5,
  parameter int BANK_BITS   = 3,
  parameter int RANK_BITS   = 1,
  parameter int COLS        = 32,
  parameter int BANKS_USED  = 4,
  parameter int SEQ_LEN     = 4,
  parameter int BYTES_W     = 32,
  parameter int CNT_W       = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               ready_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic               we_i,
  input logic [BYTES_W-1:0] bytes_i,
  input logic [CNT_W-1:0]   cnt_i,
  input logic               col_low_i
);
  localparam int CL_COL  = BLK_BITS;
  localparam int CL_BANK = CL_COL + COL_BITS;
  localparam int BL_BANK = BLK_BITS;
  localparam int BL_COL  = BL_BANK + BANK_BITS + RANK_BITS;

  logic hs, first;
  assign hs    = valid_i && ready_i;
  assign first = (cnt_i == CNT_W'(SEQ_LEN - 1));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> valid_i && $stable(addr_i) && $stable(we_i));

  p_align_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> addr_i[BLK_BITS-1:0] == '0);

  p_bank_cl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && col_low_i |-> 32'(addr_i[CL_BANK +: BANK_BITS]) < BANKS_USED);

  p_bank_bl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !col_low_i |-> 32'(addr_i[BL_BANK +: BANK_BITS]) < BANKS_USED);

  p_start_col_cl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && first && col_low_i |-> 32'(addr_i[CL_COL +: COL_BITS]) <= COLS - SEQ_LEN);

  p_start_col_bl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && first && !col_low_i |-> 32'(addr_i[BL_COL +: COL_BITS]) <= COLS - SEQ_LEN);

  p_step_cl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && (cnt_i != '0) && col_low_i |=> addr_i == $past(addr_i) + ADDR_W'(BURST_BYTES));

  p_we_series_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs && (cnt_i != '0) |=> we_i == $past(we_i));

  p_bytes_inc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> bytes_i == $past(bytes_i) + BYTES_W'(BURST_BYTES));

  p_bytes_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hs |=> $stable(bytes_i));
endmodule

bind dram_series_gen sgen_checker #(
  .ADDR_W      (ADDR_W),
  .BURST_BYTES (BURST_BYTES),
  .BLK_BITS    (BLK_BITS),
  .COL_BITS    (COL_BITS),
  .BANK_BITS   (BANK_BITS),
  .RANK_BITS   (RANK_BITS),
  .COLS        (COLS),
  .BANKS_USED  (BANKS_USED),
  .SEQ_LEN     (SEQ_LEN),
  .BYTES_W     (BYTES_W),
  .CNT_W       (CNT_W)
) i_sgen_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (req_valid_o),
  .ready_i   (req_ready_i),
  .addr_i    (req_addr_o),
  .we_i      (req_we_o),
  .bytes_i   (total_bytes_o),
  .cnt_i     (cnt_q),
  .col_low_i (col_low_q)
);

// File: tb/test_dram_series_gen.sv
module test_dram_series_gen;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] BASE       = 32'h4010_0000;
  localparam int          SEQ        = 4;
  localparam int          BURST      = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] base_i = BASE;
  logic        map_i = 1'b1;
  logic [1:0]  rw_mode_i = 2'd0;
  logic        req_valid_o, req_ready_i = 1'b0, req_we_o;
  logic [31:0] req_addr_o;
  logic [5:0]  req_size_o;
  logic [31:0] total_bytes_o;

  int     n_chk = 0, n_fail = 0;
  int     pos = 0;
  longint accepted = 0;
  logic   new_desc = 1'b1, seen_valid = 1'b0;
  logic   rec_map = 1'b1, cur_map = 1'b1;
  logic [1:0]  rec_mode = 2'd0, cur_mode = 2'd0;
  logic [31:0] prev_addr = '0;
  logic        prev_we = 1'b0;

  dram_series_gen i_dram_series_gen (
    .clk_i, .rst_ni, .base_i, .map_i, .rw_mode_i, .req_valid_o, .req_ready_i,
    .req_addr_o, .req_we_o, .req_size_o, .total_bytes_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int f_col(input logic [31:0] a, input logic m);
    return m ? int'(a[9:5]) : int'(a[13:9]);
  endfunction
  function automatic int f_bank(input logic [31:0] a, input logic m);
    return m ? int'(a[12:10]) : int'(a[7:5]);
  endfunction

  task automatic check_new();
    logic [31:0] a, e;
    a = req_addr_o;
    chk(a[4:0] == 5'd0, "R3 align", a, a & ~32'h1F);
    chk(req_size_o == 6'd32, "R3 size", req_size_o, 32);
    if (pos == 0) begin
      cur_map  = rec_map;
      cur_mode = rec_mode;
      chk(accepted % SEQ == 0, "R8", accepted % SEQ, 0);
      chk(a[31:20] == BASE[31:20], "R3 window", a[31:20], BASE[31:20]);
      chk(f_bank(a, cur_map) < 4, "R4 bank", f_bank(a, cur_map), 3);
      chk(f_col(a, cur_map) <= 32 - SEQ, "R5", f_col(a, cur_map), 32 - SEQ);
      case (cur_mode)
        2'd0: chk(req_we_o == 1'b1, "R10 write", req_we_o, 1);
        2'd1: chk(req_we_o == 1'b0, "R10 read", req_we_o, 0);
        2'd2: chk(req_we_o == !prev_we, "R10 alternate", req_we_o, !prev_we);
        default: ;
      endcase
    end else begin
      if (cur_map) begin
        chk(a == prev_addr + 32'd32, "R6", a, prev_addr + 32'd32);
      end else begin
        e = (prev_addr & ~32'h3E00) | (32'(f_col(prev_addr, 1'b0) + 1) << 9);
        chk(a == e, "R7", a, e);
      end
      chk(req_we_o == prev_we, "R9 flag", req_we_o, prev_we);
    end
    prev_addr = a;
    prev_we   = req_we_o;
    pos       = (pos + 1) % SEQ;
  endtask

  task automatic observe();
    @(negedge clk_i);
    chk(longint'(total_bytes_o) == accepted * BURST, "R11", total_bytes_o, accepted * BURST);
    if (req_valid_o) begin
      if (new_desc) check_new();
      else chk(req_addr_o == prev_addr && req_we_o == prev_we, "R2", req_addr_o, prev_addr);
      seen_valid = 1'b1;
    end else if (seen_valid) begin
      chk(1'b0, "R1 valid held", 0, 1);
    end
  endtask

  task automatic drive(input logic rdy);
    req_ready_i = rdy;
    if (req_valid_o && rdy) begin
      accepted++;
      rec_map  = map_i;
      rec_mode = rw_mode_i;
      new_desc = 1'b1;
    end else begin
      new_desc = !req_valid_o;
    end
  endtask

  task automatic cycle(input logic rdy);
    observe();
    drive(rdy);
  endtask

  // stall on the last request of a series, then apply new settings
  task automatic to_seam(input logic m, input logic [1:0] md);
    for (int i = 0; i < 64; i++) begin
      observe();
      if (req_valid_o && pos == 0) begin
        drive(1'b0);
        break;
      end
      drive(1'b1);
    end
    map_i     = m;
    rw_mode_i = md;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(req_valid_o == 1'b0, "R1 valid", req_valid_o, 0);
    chk(total_bytes_o == 32'd0, "R1 bytes", total_bytes_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_valid_o == 1'b1, "R1 first", req_valid_o, 1);
    check_new();
    drive(1'b0);
  endtask

  task automatic t_col_low_stream();
    for (int i = 0; i < 20; i++) cycle(1'b1);
  endtask

  task automatic t_stall_pattern();
    for (int i = 0; i < 30; i++) cycle((i % 3) != 0);
  endtask

  task automatic t_bank_low_read();
    to_seam(1'b0, 2'd1);
    for (int i = 0; i < 24; i++) cycle((i % 4) != 1);
  endtask

  task automatic t_alternate();
    to_seam(1'b1, 2'd2);
    for (int i = 0; i < 24; i++) cycle(1'b1);
    to_seam(1'b0, 2'd2);
    for (int i = 0; i < 24; i++) cycle((i % 5) != 2);
  endtask

  task automatic t_random_mode();
    to_seam(1'b0, 2'd3);
    for (int i = 0; i < 40; i++) cycle(1'b1);
    to_seam(1'b1, 2'd3);
    for (int i = 0; i < 40; i++) cycle((i % 2) == 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_col_low_stream();
    t_stall_pattern();
    t_bank_low_read();
    t_alternate();
    t_random_mode();
    cycle(1'b0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule